// File: doc/BRIEF.md
# Predicated Vector Unary Execution Unit

This unit executes a single predicated unary vector instruction over a vector register of `VLEN` bits, where `VLEN` is a whole number of 128-bit segments (256 by default). It takes a 32-bit instruction word, the source vector, the current contents of the destination vector and a predicate with one bit for each vector byte. It decodes the operation and the element size and applies the operation to every active element. The merged destination vector comes back one clock later, together with a flag that marks encodings the unit does not accept.

The operations fall into two families. The first covers bit counts (leading sign bits, leading zeros, set bits), a zero test that yields a boolean, sign-bit clear and sign-bit flip, and bitwise inversion. The second covers sign and zero extension from 8, 16 or 32 bits, absolute value and two's-complement negation. Whether an encoding is accepted depends on both the operation and the element size. Inactive elements keep their old destination value.

Top module: `vec_unary_unit`

## Requirements
- R1: An instruction is accepted only when bits 31:24 equal 8'b00000100 and bits 15:13 equal 3'b101. Any other word raises `out_illegal`. Bits 12:0 (predicate and register numbers) do not affect the result.
- R2: Bits 23:22 give the element size: 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. Bits 21:19 select the family: 3'b011 is the bit family and 3'b010 is the integer family. Any other family value is illegal. In the bit family, op 3'b111 is illegal and ops 3'b100 and 3'b101 are illegal at 8-bit size. In the integer family, ops 3'b000 and 3'b001 need 16 bits or more, ops 3'b010 and 3'b011 need 32 bits or more, and ops 3'b100 and 3'b101 need 64 bits.
- R3: For an illegal instruction, `out_illegal` is 1 and `out_vec` equals the old destination vector unchanged.
- R4: An inactive element keeps its old destination value. An active element takes the operation result.
- R5: An element of W bits starting at vector bit `e*W` is active exactly when predicate bit `e*W/8` is 1. The other predicate bits that cover the element are ignored.
- R6: The counting ops in the bit family are computed within the element width. Op 3'b000 counts the bits below the top bit that equal the top bit. Op 3'b001 counts the leading zero bits. Op 3'b010 counts the set bits.
- R7: The remaining bit-family ops work as follows. Op 3'b011 writes 1 when the element is zero and 0 otherwise. Op 3'b100 clears the top bit. Op 3'b101 inverts the top bit. Op 3'b110 inverts every bit.
- R8: In the integer family, ops 3'b000 and 3'b001 extend the low 8 bits of the element to the full width, ops 3'b010 and 3'b011 extend the low 16 bits, and ops 3'b100 and 3'b101 extend the low 32 bits. An even op sign-extends and an odd op zero-extends.
- R9: Integer op 3'b110 returns the absolute value and op 3'b111 returns the negation. Both wrap, so for the most negative element value each returns that same value.
- R10: `out_valid`, `out_vec` and `out_illegal` update on the rising edge at which `in_valid` is high. `out_valid` is 1 for exactly that following cycle. A synchronous active-high `rst` clears `out_valid` and `out_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present |
| instr | input | 32 | Instruction word |
| src_vec | input | VLEN | Source vector |
| old_dst | input | VLEN | Current destination vector |
| pred | input | VLEN/8 | Governing predicate, one bit per byte |
| out_valid | output | 1 | Result present |
| out_vec | output | VLEN | Merged destination vector |
| out_illegal | output | 1 | Encoding not accepted |

## Verification
The hardest case to reach is a predicate in which an element's lowest-byte bit disagrees with its upper-byte bits. Random predicates seldom make every such bit disagree at 64-bit size. The bench therefore builds predicates by hand that set every upper-byte bit and clear every lowest-byte bit, and then the reverse, and checks that all elements stay unchanged and then all change. The sign-boundary value for absolute value and negation is also unlikely at random, so the bench fills every element with the most negative value at each size.

// File: rtl/vec_unary_unit.sv
module vec_unary_unit #(
  parameter int VLEN = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [VLEN-1:0]   src_vec,
  input  logic [VLEN-1:0]   old_dst,
  input  logic [VLEN/8-1:0] pred,
  output logic              out_valid,
  output logic [VLEN-1:0]   out_vec,
  output logic              out_illegal
);

  logic [1:0] sz;
  logic [2:0] fam, op;
  logic       hit, legal;
  logic       unused_fields;

  assign sz  = instr[23:22];
  assign fam = instr[21:19];
  assign op  = instr[18:16];
  assign hit = (instr[31:24] == 8'b0000_0100) && (instr[15:13] == 3'b101);
  assign unused_fields = ^instr[12:0];

  always_comb begin
    legal = 1'b0;
    if (hit) begin
      if (fam == 3'b011) begin
        case (op)
          3'b100, 3'b101: legal = (sz != 2'd0);
          3'b111:         legal = 1'b0;
          default:        legal = 1'b1;
        endcase
      end else if (fam == 3'b010) begin
        case (op)
          3'b000, 3'b001: legal = (sz != 2'd0);
          3'b010, 3'b011: legal = sz[1];
          3'b100, 3'b101: legal = (sz == 2'd3);
          default:        legal = 1'b1;
        endcase
      end
    end
  end

  logic [VLEN-1:0] merged [4];

  generate
    for (genvar s = 0; s < 4; s++) begin : g_sz
      localparam int W  = 8 << s;
      localparam int NE = VLEN / W;
      localparam int IW = $clog2(W);
      logic [VLEN-1:0] m;

      for (genvar e = 0; e < NE; e++) begin : g_el
        logic [W-1:0] x, r;
        assign x = src_vec[e*W +: W];

        always_comb begin
          int          n;
          int          lb;
          logic        run;
          logic        sx;
          logic [IW-1:0] li;
          n   = 0;
          lb  = 0;
          run = 1'b1;
          sx  = 1'b0;
          li  = '0;
          r   = x;
          case ({instr[19], op})
            4'b1000: begin
              for (int k = W - 2; k >= 0; k--)
                if (run && (x[k] == x[W-1])) n = n + 1;
                else run = 1'b0;
              r = W'(n);
            end
            4'b1001: begin
              for (int k = W - 1; k >= 0; k--)
                if (run && !x[k]) n = n + 1;
                else run = 1'b0;
              r = W'(n);
            end
            4'b1010: begin
              for (int k = 0; k < W; k++) n = n + int'(x[k]);
              r = W'(n);
            end
            4'b1011: r = {{(W-1){1'b0}}, (x == '0)};
            4'b1100: r = {1'b0, x[W-2:0]};
            4'b1101: r = {~x[W-1], x[W-2:0]};
            4'b1110: r = ~x;
            4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101: begin
              lb = (8 << op[2:1]) - 1;
              if (lb > W - 1) lb = W - 1;
              li = IW'(lb);
              sx = ~op[0] & x[li];
              for (int k = 0; k < W; k++) r[k] = (k <= lb) ? x[k] : sx;
            end
            4'b0110: r = x[W-1] ? -x : x;
            4'b0111: r = -x;
            default: r = x;
          endcase
        end

        assign m[e*W +: W] = pred[e*W/8] ? r : old_dst[e*W +: W];
      end

      assign merged[s] = m;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_illegal <= ~legal;
        out_vec     <= legal ? merged[sz] : old_dst;
      end
    end
  end

endmodule

// File: rtl/vec_unary_unit_chk.sv
module vec_unary_unit_chk #(
  parameter int VLEN = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [31:0]       instr,
  input logic [VLEN-1:0]   old_dst,
  input logic [VLEN/8-1:0] pred,
  input logic              out_valid,
  input logic [VLEN-1:0]   out_vec,
  input logic              out_illegal
);

  a_r1_unmatched_flagged: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:24] != 8'b0000_0100) |=> out_illegal);

  a_r2_word_ext_size: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:24] == 8'b0000_0100 && instr[15:13] == 3'b101 &&
     instr[21:17] == 5'b01010 && instr[23:22] != 2'b11) |=> out_illegal);

  a_r3_illegal_keeps_old: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !out_valid) ##1 (out_valid && out_illegal) |-> out_vec == $past(old_dst));

  a_r4_no_active_keeps_old: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pred == '0) |=> out_vec == $past(old_dst));

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r10_idle_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

endmodule

bind vec_unary_unit vec_unary_unit_chk #(.VLEN(VLEN)) i_chk (.*);

// File: tb/test_vec_unary_unit.sv
`timescale 1ns/1ps
module test_vec_unary_unit;
  localparam int VLEN = 256;
  localparam int PW   = VLEN / 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [31:0]     instr = '0;
  logic [VLEN-1:0] src_vec = '0, old_dst = '0;
  logic [PW-1:0]   pred = '0;
  logic            out_valid, out_illegal;
  logic [VLEN-1:0] out_vec;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vec_unary_unit #(.VLEN(VLEN)) i_vec_unary_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_vec(src_vec), .old_dst(old_dst), .pred(pred),
    .out_valid(out_valid), .out_vec(out_vec), .out_illegal(out_illegal));

  function automatic logic [31:0] mk(logic [2:0] f, logic [2:0] o, logic [1:0] s);
    return {8'b0000_0100, s, f, o, 3'b101, 3'($urandom), 5'($urandom), 5'($urandom)};
  endfunction

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic bit ref_illegal(logic [31:0] ins);
    int s, mn;
    s = int'(ins[23:22]);
    if (ins[31:24] != 8'h04 || ins[15:13] != 3'b101) return 1;
    if (ins[21:19] == 3'b011) begin
      if (ins[18:16] == 3'd7) return 1;
      mn = (ins[18:16] == 3'd4 || ins[18:16] == 3'd5) ? 1 : 0;
    end else if (ins[21:19] == 3'b010) begin
      mn = (ins[18:16] >= 3'd6) ? 0 : int'(ins[18:17]) + 1;
    end else return 1;
    return s < mn;
  endfunction

  function automatic longint unsigned ref_op(logic [31:0] ins, int w, longint unsigned x);
    longint unsigned mk_, top, lo, r;
    int n, l;
    mk_ = (w == 64) ? '1 : ((64'd1 << w) - 1);
    top = 64'd1 << (w - 1);
    n = 0;
    r = x;
    if (ins[21:19] == 3'b011) begin
      case (ins[18:16])
        3'd0: begin
          for (int k = w - 2; k >= 0; k--)
            if (((x >> k) & 1) == ((x >> (w - 1)) & 1)) n++; else break;
          r = longint'(n);
        end
        3'd1: begin
          for (int k = w - 1; k >= 0; k--) if (((x >> k) & 1) == 0) n++; else break;
          r = longint'(n);
        end
        3'd2: r = longint'($countones(x));
        3'd3: r = (x == 0) ? 1 : 0;
        3'd4: r = x & ~top;
        3'd5: r = x ^ top;
        default: r = ~x & mk_;
      endcase
    end else begin
      if (ins[18:16] == 3'd6) r = (x & top) ? ((-x) & mk_) : x;
      else if (ins[18:16] == 3'd7) r = (-x) & mk_;
      else begin
        l = 8 << ins[18:17];
        lo = x & ((64'd1 << l) - 1);
        if (!ins[16] && ((lo >> (l - 1)) & 1)) lo = lo | (mk_ & ~((64'd1 << l) - 1));
        r = lo;
      end
    end
    return r & mk_;
  endfunction

  function automatic logic [VLEN-1:0] ref_vec(logic [31:0] ins, logic [VLEN-1:0] s,
                                              logic [VLEN-1:0] o, logic [PW-1:0] p);
    logic [VLEN-1:0] v;
    int w;
    longint unsigned x, r;
    v = o;
    if (ref_illegal(ins)) return v;
    w = 8 << ins[23:22];
    for (int e = 0; e < VLEN / w; e++) begin
      if (p[e*w/8]) begin
        x = 64'(s >> (e * w));
        if (w < 64) x = x & ((64'd1 << w) - 1);
        r = ref_op(ins, w, x);
        for (int b = 0; b < w; b++) v[e*w + b] = r[b];
      end
    end
    return v;
  endfunction

  task automatic chk_bit(string tag, logic got, logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic chk_vec(string tag, logic [VLEN-1:0] got, logic [VLEN-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(logic [31:0] ins, logic [VLEN-1:0] s, logic [VLEN-1:0] o, logic [PW-1:0] p);
    @(negedge clk);
    instr = ins; src_vec = s; old_dst = o; pred = p; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_model(string tag, logic [31:0] ins, logic [VLEN-1:0] s,
                           logic [VLEN-1:0] o, logic [PW-1:0] p);
    issue(ins, s, o, p);
    chk_bit({tag, " R10 valid"}, out_valid, 1'b1);
    chk_bit({tag, " flag"}, out_illegal, ref_illegal(ins));
    chk_vec({tag, " data"}, out_vec, ref_vec(ins, s, o, p));
  endtask

  task automatic t_reset();
    chk_bit("R10 reset out_valid", out_valid, 1'b0);
    chk_bit("R10 reset out_illegal", out_illegal, 1'b0);
  endtask

  task automatic t_counts();
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 3; o++) begin
        logic [VLEN-1:0] v;
        v = rnd_vec();
        v[15:0] = 16'h0000;
        v[VLEN-1 -: 16] = 16'hFFFF;
        run_model("R6 count full", mk(3'b011, 3'(o), 2'(s)), v, rnd_vec(), '1);
        run_model("R6 count pred", mk(3'b011, 3'(o), 2'(s)), rnd_vec(), rnd_vec(), PW'(rnd_vec()));
      end
  endtask

  task automatic t_bitops();
    for (int s = 0; s < 4; s++)
      for (int o = 3; o < 7; o++) begin
        logic [VLEN-1:0] v;
        v = rnd_vec();
        v[63:0] = '0;
        run_model("R7 bitop", mk(3'b011, 3'(o), 2'(s)), v, rnd_vec(), PW'(rnd_vec()) | 1);
      end
  endtask

  task automatic t_ext();
    for (int s = 1; s < 4; s++)
      for (int o = 0; o < 6; o++)
        if (s >= (o / 2) + 1)
          run_model("R8 extend", mk(3'b010, 3'(o), 2'(s)), rnd_vec(), rnd_vec(), '1);
  endtask

  task automatic t_wrap();
    for (int s = 0; s < 4; s++) begin
      logic [VLEN-1:0] v;
      int w;
      w = 8 << s;
      v = '0;
      for (int e = 0; e < VLEN / w; e++) v[e*w + w - 1] = 1'b1;
      issue(mk(3'b010, 3'd6, 2'(s)), v, rnd_vec(), '1);
      chk_vec("R9 abs wrap", out_vec, v);
      issue(mk(3'b010, 3'd7, 2'(s)), v, rnd_vec(), '1);
      chk_vec("R9 neg wrap", out_vec, v);
      run_model("R9 abs random", mk(3'b010, 3'd6, 2'(s)), rnd_vec(), rnd_vec(), '1);
      run_model("R9 neg random", mk(3'b010, 3'd7, 2'(s)), rnd_vec(), rnd_vec(), '1);
    end
  endtask

  task automatic t_pred();
    logic [VLEN-1:0] s, o;
    s = rnd_vec();
    o = rnd_vec();
    issue(mk(3'b011, 3'd6, 2'd3), s, o, {(PW/8){8'hFE}});
    chk_vec("R5 upper bytes ignored", out_vec, o);
    issue(mk(3'b011, 3'd6, 2'd3), s, o, {(PW/8){8'h01}});
    chk_vec("R5 low byte governs", out_vec, ~s);
    issue(mk(3'b011, 3'd6, 2'd1), s, o, {(PW/2){2'b01}});
    chk_vec("R5 halfword low byte", out_vec, ~s);
    issue(mk(3'b011, 3'd6, 2'd0), s, o, '0);
    chk_vec("R4 none active", out_vec, o);
    run_model("R4 mixed", mk(3'b010, 3'd7, 2'd2), s, o, PW'(rnd_vec()));
  endtask

  task automatic t_illegal();
    logic [31:0] bad [9];
    logic [VLEN-1:0] s, o;
    bad[0] = mk(3'b011, 3'd4, 2'd0);
    bad[1] = mk(3'b011, 3'd5, 2'd0);
    bad[2] = mk(3'b011, 3'd7, 2'd2);
    bad[3] = mk(3'b010, 3'd1, 2'd0);
    bad[4] = mk(3'b010, 3'd2, 2'd1);
    bad[5] = mk(3'b010, 3'd5, 2'd2);
    bad[6] = mk(3'b000, 3'd0, 2'd2);
    bad[7] = mk(3'b011, 3'd0, 2'd0) ^ 32'h0100_0000;
    bad[8] = mk(3'b011, 3'd0, 2'd0) ^ 32'h0000_4000;
    foreach (bad[i]) begin
      s = rnd_vec();
      o = rnd_vec();
      issue(bad[i], s, o, '1);
      chk_bit("R2 illegal flag", out_illegal, 1'b1);
      chk_vec("R3 illegal keeps old", out_vec, o);
    end
    run_model("R2 word ext legal", mk(3'b010, 3'd4, 2'd3), rnd_vec(), rnd_vec(), '1);
    run_model("R1 fields ignored", mk(3'b011, 3'd2, 2'd2), rnd_vec(), rnd_vec(), '1);
  endtask

  task automatic t_timing();
    logic [VLEN-1:0] held;
    run_model("R10 single", mk(3'b011, 3'd1, 2'd1), rnd_vec(), rnd_vec(), '1);
    held = out_vec;
    @(negedge clk);
    chk_bit("R10 valid drops", out_valid, 1'b0);
    chk_vec("R10 data holds", out_vec, held);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_counts();
    t_bitops();
    t_ext();
    t_wrap();
    t_pred();
    t_illegal();
    t_timing();
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end
endmodule